// File: doc/BRIEF.md
# Four-Bit Single-Cycle Micro Core

This block is a very small processor. Its data words are 4-bit two's-complement values and its instructions are 16 bits wide. It holds a 16-word program store, a 16-word data store of 4-bit words, eight general registers, an arithmetic unit and a program counter. A host fills both stores one word per clock through their own address, data and write-enable pins. It then pulses `clear`, which empties the registers and points the counter at word 0. From the clock after `clear` drops, the core retires one instruction per cycle until it stops itself.

An instruction is split into five fields. The top nibble selects the kind of instruction. Three 3-bit fields follow that name registers, and the lowest 3 bits carry an operation code, a data address or a jump target. Data addresses and jump targets are zero-extended to 4 bits, so programs reach only the lower half of each store. When execution has stopped, the host reads the data store through a combinational read port.

Top module: `tiny4_core`

## Requirements
- R1: After synchronous reset `pc` is 0 and `done` is 0, and no instruction executes until `clear` has been pulsed.
- R2: Host writes (`imem_we`, `dmem_we`) are taken only when the core is not running, meaning it is idle, stopped, or `clear` is high. While the core is running they are dropped.
- R3: While `clear` is high the eight registers read as 0, `pc` is 0 and `done` is 0. On the first clock edge after `clear` falls, the instruction at word 0 executes, and after that one instruction executes per clock.
- R4: Opcode 0000 (bits [15:12]) writes register [5:3] with register [11:9] combined with register [8:6], modulo 16. The function in [2:0] selects the operation: 000 add, 001 subtract, 010 AND, 011 XOR. Functions 1xx leave every register unchanged. The counter then advances by one.
- R5: Opcode 0001 copies data word {0,[2:0]} into register [11:9].
- R6: Opcode 0010 writes register [11:9] into data word {0,[2:0]}. Words 8 to 15 cannot be reached by a program.
- R7: Opcode 0011 loads `pc` with {0,[2:0]} if register [11:9] equals register [8:6]. Otherwise `pc` advances by one.
- R8: Opcode 0100 always loads `pc` with {0,[2:0]}.
- R9: Opcodes 0101 to 1111 raise `done` at the next edge, leave `pc` on that instruction's address and change no register or data word.
- R10: If the instruction at address 15 does not jump, it executes and `done` rises at the same edge, with `pc` held at 15.
- R11: Whenever the core is not running, `dmem_rdata` shows the data word at `dmem_addr`.
- R12: Once `done` is high it stays high and `pc` stays constant until `clear` or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Clears registers and restarts execution from word 0 |
| imem_we | input | 1 | Host program-store write enable |
| imem_addr | input | 4 | Host program-store address |
| imem_wdata | input | 16 | Host program word |
| dmem_we | input | 1 | Host data-store write enable |
| dmem_addr | input | 4 | Host data-store address (write and read) |
| dmem_wdata | input | 4 | Host data word |
| dmem_rdata | output | 4 | Data word at `dmem_addr` while not running |
| pc | output | 4 | Program counter |
| done | output | 1 | Execution has stopped |

## Verification
The bench aims at four corner cases. The first is a subtraction that goes negative and an addition that wraps past 7; a unit that did not wrap modulo 16 would store the wrong nibble. The second is a compare-and-jump that first falls through and is later taken; a core that inverted the test or jumped relative to the counter would leave a different trace of `pc` values. The third is a program running off the end of the store, which must stop at address 15 after exactly sixteen instructions rather than wrap to 0. The fourth is host writes issued during a tight loop; if they leaked into the stores, an injected stop word would end the loop early.

// File: rtl/tiny4_pkg.sv
package tiny4_pkg;

    localparam int DW      = 4;
    localparam int IW      = 16;
    localparam int NREG    = 8;
    localparam int RAW     = $clog2(NREG);
    localparam int IM_DEPTH = 16;
    localparam int DM_DEPTH = 16;
    localparam int IAW     = $clog2(IM_DEPTH);
    localparam int DAW     = $clog2(DM_DEPTH);

    localparam logic [3:0] OPC_ARITH = 4'h0;
    localparam logic [3:0] OPC_LOAD  = 4'h1;
    localparam logic [3:0] OPC_STORE = 4'h2;
    localparam logic [3:0] OPC_BEQ   = 4'h3;
    localparam logic [3:0] OPC_JP    = 4'h4;

    localparam logic [2:0] FN_ADD = 3'd0;
    localparam logic [2:0] FN_SUB = 3'd1;
    localparam logic [2:0] FN_AND = 3'd2;
    localparam logic [2:0] FN_XOR = 3'd3;

    typedef struct packed {
        logic [3:0] opc;
        logic [2:0] ra;
        logic [2:0] rb;
        logic [2:0] rc;
        logic [2:0] lo;
    } insn_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } core_st_e;

    typedef struct packed {
        logic          wr;
        logic [DW-1:0] y;
    } alu_res_t;

    function automatic alu_res_t alu_eval(input logic [2:0] fn,
                                          input logic [DW-1:0] a,
                                          input logic [DW-1:0] b);
        alu_res_t r;
        r.wr = 1'b1;
        unique case (fn)
            FN_ADD:  r.y = a + b;
            FN_SUB:  r.y = a - b;
            FN_AND:  r.y = a & b;
            FN_XOR:  r.y = a ^ b;
            default: begin
                r.wr = 1'b0;
                r.y  = '0;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tiny4_alu.sv
module tiny4_alu
    import tiny4_pkg::*;
(
    input  logic [2:0]    fn,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic          wr,
    output logic [DW-1:0] y,
    output logic          eq
);
    alu_res_t res;

    always_comb begin
        res = alu_eval(fn, a, b);
        wr  = res.wr;
        y   = res.y;
        eq  = (a == b);
    end
endmodule

// File: rtl/tiny4_ram.sv
module tiny4_ram #(
    parameter int W     = 4,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tiny4_regfile.sv
module tiny4_regfile #(
    parameter int W = 4,
    parameter int N = 8,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);
    logic [N-1:0][W-1:0] regs_q;

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst || clr)                      regs_q[g] <= '0;
            else if (we && waddr == AW'(g))      regs_q[g] <= wdata;
        end
    end

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];

    // R3: a clear leaves every register at zero
    p_clear_zero_r3: assert property (@(posedge clk) disable iff (rst)
        clr |=> (regs_q == '0));

    // R4: no write strobe means no register moves
    p_hold_no_we_r4: assert property (@(posedge clk) disable iff (rst)
        (!we && !clr) |=> $stable(regs_q));
endmodule

// File: rtl/tiny4_core.sv
module tiny4_core
    import tiny4_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           clear,
    input  logic           imem_we,
    input  logic [IAW-1:0] imem_addr,
    input  logic [IW-1:0]  imem_wdata,
    input  logic           dmem_we,
    input  logic [DAW-1:0] dmem_addr,
    input  logic [DW-1:0]  dmem_wdata,
    output logic [DW-1:0]  dmem_rdata,
    output logic [IAW-1:0] pc,
    output logic           done
);
    core_st_e       st_q;
    logic [IAW-1:0] pc_q;
    logic           done_q;

    logic           running;
    logic           host_ok;
    logic [IW-1:0]  imem_q;
    insn_t          ins;

    logic [DW-1:0]  ra_val, rb_val, alu_y, dm_q;
    logic           alu_wr, alu_eq;

    logic [DAW-1:0] d_core_addr;
    logic           d_we;
    logic [DAW-1:0] d_waddr, d_raddr;
    logic [DW-1:0]  d_wdata;

    logic           rf_we;
    logic [RAW-1:0] rf_waddr;
    logic [DW-1:0]  rf_wdata;

    logic [IAW:0]   pc_inc;
    logic [IAW-1:0] tgt;
    logic           take, halt_op;

    assign running = (st_q == ST_RUN) && !clear;
    assign host_ok = !running;
    assign ins     = insn_t'(imem_q);

    // program store
    tiny4_ram #(.W(IW), .DEPTH(IM_DEPTH)) u_imem (
        .clk   (clk),
        .we    (imem_we && host_ok),
        .waddr (imem_addr),
        .wdata (imem_wdata),
        .raddr (pc_q),
        .rdata (imem_q)
    );

    // data store: host owns it unless running
    assign d_core_addr = DAW'(ins.lo);
    assign d_we    = host_ok ? dmem_we : (ins.opc == OPC_STORE);
    assign d_waddr = host_ok ? dmem_addr : d_core_addr;
    assign d_wdata = host_ok ? dmem_wdata : ra_val;
    assign d_raddr = running ? d_core_addr : dmem_addr;

    tiny4_ram #(.W(DW), .DEPTH(DM_DEPTH)) u_dmem (
        .clk   (clk),
        .we    (d_we),
        .waddr (d_waddr),
        .wdata (d_wdata),
        .raddr (d_raddr),
        .rdata (dm_q)
    );
    assign dmem_rdata = dm_q;

    tiny4_alu u_alu (
        .fn (ins.lo),
        .a  (ra_val),
        .b  (rb_val),
        .wr (alu_wr),
        .y  (alu_y),
        .eq (alu_eq)
    );

    assign rf_we    = running && (((ins.opc == OPC_ARITH) && alu_wr) || (ins.opc == OPC_LOAD));
    assign rf_waddr = (ins.opc == OPC_LOAD) ? ins.ra : ins.rc;
    assign rf_wdata = (ins.opc == OPC_LOAD) ? dm_q : alu_y;

    tiny4_regfile #(.W(DW), .N(NREG)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .clr     (clear),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (ins.ra),
        .raddr_b (ins.rb),
        .rdata_a (ra_val),
        .rdata_b (rb_val)
    );

    // next-address selection
    assign pc_inc = {1'b0, pc_q} + 1'b1;
    assign tgt    = IAW'(ins.lo);

    always_comb begin
        take    = 1'b0;
        halt_op = 1'b0;
        unique case (ins.opc)
            OPC_ARITH, OPC_LOAD, OPC_STORE: ;
            OPC_BEQ: take = alu_eq;
            OPC_JP:  take = 1'b1;
            default: halt_op = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            pc_q   <= '0;
            done_q <= 1'b0;
        end else if (clear) begin
            st_q   <= ST_RUN;
            pc_q   <= '0;
            done_q <= 1'b0;
        end else if (running) begin
            if (halt_op) begin
                st_q   <= ST_HALT;
                done_q <= 1'b1;
            end else if (take) begin
                pc_q <= tgt;
            end else if (pc_inc[IAW]) begin
                st_q   <= ST_HALT;
                done_q <= 1'b1;
            end else begin
                pc_q <= pc_inc[IAW-1:0];
            end
        end
    end

    assign pc   = pc_q;
    assign done = done_q;

    // R1: idle core does not move the counter
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && !clear) |=> (pc == '0 && !done));

    // R4: arithmetic below the last word steps by one
    p_arith_step_r4: assert property (@(posedge clk) disable iff (rst)
        (running && ins.opc == OPC_ARITH && pc_q != '1) |=> (pc == $past(pc) + 1'b1));

    // R8: unconditional jump lands on its target
    p_jump_lands_r8: assert property (@(posedge clk) disable iff (rst)
        (running && ins.opc == OPC_JP) |=> (pc == $past(tgt)));

    // R9: unknown opcode stops the core in place
    p_bad_opc_stop_r9: assert property (@(posedge clk) disable iff (rst)
        (running && ins.opc > OPC_JP) |=> (done && $stable(pc)));

    // R12: stopped state is sticky
    p_done_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        (done && !clear) |=> (done && $stable(pc)));
endmodule

// File: tb/tiny4_core_tb.sv
`timescale 1ns/100ps
module tiny4_core_tb;

    logic        clk = 1'b0;
    logic        rst, clear, imem_we, dmem_we;
    logic [3:0]  imem_addr, dmem_addr, dmem_wdata;
    logic [15:0] imem_wdata;
    logic [3:0]  dmem_rdata, pc;
    logic        done;

    always #2.5 clk = ~clk;

    tiny4_core u_dut (
        .clk(clk), .rst(rst), .clear(clear),
        .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
        .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_rdata(dmem_rdata), .pc(pc), .done(done)
    );

    int    nchk = 0, nerr = 0, cyc = 0;
    bit    chk_en = 0, mem_ok = 0;
    string cur_req = "R1";

    // behavioural reference state
    logic [15:0] m_im [16];
    int          m_dm [16];
    int          m_rf [8];
    int          m_pc, m_st, m_done;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // reference model: one update per rising edge
    always @(posedge clk) begin
        logic [15:0] w;
        int op, ra, rb, rc, lo, nxt;
        bit run, halt;
        cyc++;
        if (rst) begin
            m_st = 0; m_pc = 0; m_done = 0;
            for (int i = 0; i < 8; i++) m_rf[i] = 0;
        end else begin
            run = (m_st == 1) && !clear;
            if (!run) begin
                if (imem_we) m_im[imem_addr] = imem_wdata;
                if (dmem_we) m_dm[dmem_addr] = int'(dmem_wdata);
            end
            if (clear) begin
                for (int i = 0; i < 8; i++) m_rf[i] = 0;
                m_pc = 0; m_done = 0; m_st = 1;
            end else if (run) begin
                w  = m_im[m_pc];
                op = int'(w[15:12]); ra = int'(w[11:9]); rb = int'(w[8:6]);
                rc = int'(w[5:3]);   lo = int'(w[2:0]);
                nxt = m_pc + 1; halt = 0;
                case (op)
                    0: case (lo)
                           0: m_rf[rc] = (m_rf[ra] + m_rf[rb]) & 15;
                           1: m_rf[rc] = (m_rf[ra] - m_rf[rb]) & 15;
                           2: m_rf[rc] = m_rf[ra] & m_rf[rb];
                           3: m_rf[rc] = m_rf[ra] ^ m_rf[rb];
                           default: ;
                       endcase
                    1: m_rf[ra] = m_dm[lo];
                    2: m_dm[lo] = m_rf[ra];
                    3: if (m_rf[ra] == m_rf[rb]) nxt = lo;
                    4: nxt = lo;
                    default: halt = 1;
                endcase
                if (halt || nxt > 15) begin m_done = 1; m_st = 2; end
                else m_pc = nxt;
            end
        end
        if (cyc > 50000) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (chk_en && !rst) begin
            chk(pc == m_pc[3:0], cur_req, int'(pc), m_pc);
            chk(done == m_done[0], cur_req, int'(done), m_done);
            if (mem_ok && !((m_st == 1) && !clear))
                chk(int'(dmem_rdata) == m_dm[dmem_addr], "R11", int'(dmem_rdata), m_dm[dmem_addr]);
        end
    end

    task automatic go();
        @(negedge clk); #1;
    endtask

    task automatic wr_im(input logic [3:0] a, input logic [15:0] wd);
        imem_we = 1; imem_addr = a; imem_wdata = wd; go(); imem_we = 0;
    endtask

    task automatic wr_dm(input logic [3:0] a, input logic [3:0] v);
        dmem_we = 1; dmem_addr = a; dmem_wdata = v; go(); dmem_we = 0;
    endtask

    task automatic rd_dm(input logic [3:0] a, input logic [3:0] exp, input string req);
        dmem_addr = a; #1;
        chk(dmem_rdata == exp, req, int'(dmem_rdata), int'(exp));
    endtask

    task automatic start_and_wait(output int n);
        clear = 1; go(); clear = 0;
        n = 0;
        while (!done && n < 400) begin go(); n++; end
    endtask

    function automatic logic [15:0] i_ar(input int a, b, c, f);
        return {4'h0, 3'(a), 3'(b), 3'(c), 3'(f)};
    endfunction
    function automatic logic [15:0] i_ld(input int a, m);
        return {4'h1, 3'(a), 6'b0, 3'(m)};
    endfunction
    function automatic logic [15:0] i_st(input int a, m);
        return {4'h2, 3'(a), 6'b0, 3'(m)};
    endfunction
    function automatic logic [15:0] i_beq(input int a, b, t);
        return {4'h3, 3'(a), 3'(b), 3'b0, 3'(t)};
    endfunction
    function automatic logic [15:0] i_jp(input int t);
        return {4'h4, 9'b0, 3'(t)};
    endfunction
    localparam logic [15:0] HALT = 16'hF000;

    initial begin
        logic [15:0] prog [16];
        int n;
        logic [3:0] pc_keep;
        rst = 1; clear = 0; imem_we = 0; dmem_we = 0;
        imem_addr = 0; dmem_addr = 0; dmem_wdata = 0; imem_wdata = 0;
        for (int i = 0; i < 16; i++) begin m_im[i] = 16'h0; m_dm[i] = 0; end
        go(); go(); go();
        rst = 0; go();
        // R1: reset state
        chk(pc == 4'd0, "R1", int'(pc), 0);
        chk(done == 1'b0, "R1", int'(done), 0);
        chk_en = 1;

        // ---- arithmetic, load, store (R4 R5 R6) ----
        cur_req = "R1";
        for (int i = 0; i < 16; i++) prog[i] = HALT;
        prog[0]  = i_ld(0, 0);
        prog[1]  = i_ld(1, 1);
        prog[2]  = i_ar(0, 1, 2, 0);
        prog[3]  = i_ar(0, 1, 3, 1);
        prog[4]  = i_ar(0, 1, 4, 2);
        prog[5]  = i_ar(0, 1, 5, 3);
        prog[6]  = i_ld(6, 0);
        prog[7]  = i_ar(0, 1, 6, 5);
        prog[8]  = i_st(2, 2);
        prog[9]  = i_st(3, 3);
        prog[10] = i_st(4, 4);
        prog[11] = i_st(5, 5);
        prog[12] = i_st(6, 6);
        prog[13] = i_st(0, 7);
        for (int i = 0; i < 16; i++) wr_im(4'(i), prog[i]);
        for (int i = 0; i < 16; i++) wr_dm(4'(i), 4'd9);
        wr_dm(4'd0, 4'd5);
        wr_dm(4'd1, 4'd7);
        mem_ok = 1;
        go(); go();
        chk(pc == 4'd0, "R1", int'(pc), 0);   // idle core stays put
        cur_req = "R3";
        clear = 1; go(); clear = 0; go();
        chk(pc == 4'd1, "R3", int'(pc), 1);   // first instruction on first edge
        cur_req = "R4";
        n = 0;
        while (!done && n < 400) begin go(); n++; end
        chk(pc == 4'd14, "R9", int'(pc), 14);
        rd_dm(4'd2, 4'hC, "R4");  // 5+7 wraps
        rd_dm(4'd3, 4'hE, "R4");  // 5-7 = -2
        rd_dm(4'd4, 4'h5, "R4");
        rd_dm(4'd5, 4'h2, "R4");
        rd_dm(4'd6, 4'h5, "R4");  // function 101 left r6 alone
        rd_dm(4'd7, 4'h5, "R5");
        rd_dm(4'd10, 4'h9, "R6"); // upper half out of program reach

        // ---- branch and jump (R7 R8), clear held (R3) ----
        cur_req = "R3";
        clear = 1; go(); go(); go();
        chk(done == 1'b0, "R3", int'(done), 0);
        chk(pc == 4'd0, "R3", int'(pc), 0);
        for (int i = 0; i < 16; i++) prog[i] = HALT;
        prog[0] = i_ld(1, 0);
        prog[1] = i_ld(2, 1);
        prog[2] = i_beq(1, 2, 5);
        prog[3] = i_ld(2, 0);
        prog[4] = i_jp(2);
        prog[5] = i_st(2, 7);
        for (int i = 0; i < 16; i++) wr_im(4'(i), prog[i]);
        for (int i = 0; i < 16; i++) wr_dm(4'(i), 4'(i));
        wr_dm(4'd0, 4'd3);
        wr_dm(4'd1, 4'd6);
        clear = 0;
        cur_req = "R7";
        start_and_wait(n);
        chk(n == 8, "R7", n, 8);
        chk(pc == 4'd6, "R8", int'(pc), 6);
        rd_dm(4'd7, 4'h3, "R7");

        // ---- done sticky (R12) ----
        cur_req = "R12";
        pc_keep = pc;
        for (int i = 0; i < 4; i++) begin
            go();
            chk(done == 1'b1, "R12", int'(done), 1);
            chk(pc == pc_keep, "R12", int'(pc), int'(pc_keep));
        end

        // ---- run off the end (R10) ----
        cur_req = "R10";
        for (int i = 0; i < 16; i++) wr_im(4'(i), 16'h0000);
        start_and_wait(n);
        chk(n == 16, "R10", n, 16);
        chk(pc == 4'd15, "R10", int'(pc), 15);

        // ---- host writes while running are dropped (R2) ----
        cur_req = "R2";
        wr_im(4'd0, i_jp(0));
        clear = 1; go(); clear = 0; go(); go();
        wr_im(4'd0, HALT);
        wr_dm(4'd3, 4'hF);
        go(); go(); go();
        chk(done == 1'b0, "R2", int'(done), 0);
        // accepted while clear is held
        clear = 1; imem_we = 1; imem_addr = 4'd0; imem_wdata = HALT; go();
        imem_we = 0; clear = 0; go();
        chk(done == 1'b1, "R9", int'(done), 1);
        chk(pc == 4'd0, "R9", int'(pc), 0);
        rd_dm(4'd3, 4'h3, "R2");

        go(); go();
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule